// File: doc/BRIEF.md
# Alarm comparator with snooze rearm

This block decides, once per clock, whether an alarm indicator should be driven. It compares the current time of day with a compare target. Both are 16-bit BCD values. While the block is not snoozing, the target is the user's programmed alarm time. A light beam across a doorway feeds a detector input. When someone breaks the beam, the detector input goes from high to low. That transition re-arms the alarm for the current time plus a fixed snooze interval, two minutes by default.

The alarm output is high only when three conditions hold together: the main enable switch is on, the current time equals the active target, and the detector input is high. Snoozing repeats on every later beam break, and each break re-arms from the time at that moment. Turning the main switch off ends snooze mode, so the programmed alarm time applies again. Keeping the time and setting it are done elsewhere. The reset input is asynchronous and active low, and the block releases it in step with the clock.

Top module: `alarm_snooze_cmp`

## Requirements
- R1: `alarm_out` is registered. After a rising clock edge it is 1 exactly when, at that edge, `main_on` was 1, `beam_in` was 1, and `now_time` equalled the active target; otherwise it is 0.
- R2: When not in snooze mode, the active target is `alarm_time`.
- R3: A falling edge on `beam_in` is `beam_in` sampled 1 at one clock edge and 0 at the next. If `main_on` is 1 at that second edge, the block enters snooze mode, and from the following edge on the target is `now_time` plus two minutes, where `now_time` is the value sampled at that second edge.
- R4: Times are BCD. Bits [15:12] hold the hour tens, [11:8] the hour units, [7:4] the minute tens and [3:0] the minute units. The snooze addition carries past minute 59 into the next hour, and it wraps hour 23 round to hour 00.
- R5: Each later falling edge of `beam_in` while `main_on` is 1 reloads the target from the `now_time` of that edge.
- R6: A clock edge with `main_on` at 0 leaves the block out of snooze mode, so `alarm_time` is the target again. This takes priority over a coincident falling edge.
- R7: While reset is active, `alarm_out` is 0 and the block is not in snooze mode. The stored previous detector level resets to 0, so a low `beam_in` just after reset is not a falling edge.
- R8: A falling edge of `beam_in` while `main_on` is 0 does not enter snooze mode.
- R9: A rising edge of `beam_in` leaves the target unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| main_on | input | 1 | Main enable switch |
| beam_in | input | 1 | Light detector level; high while the beam is unbroken |
| now_time | input | 16 | Current time, BCD hh:mm |
| alarm_time | input | 16 | Programmed alarm time, BCD hh:mm |
| alarm_out | output | 1 | Alarm indicator |

## Verification
The assertions assume that `now_time` always holds a legal 24-hour BCD time: minute tens no more than 5, units no more than 9, and hours below 24. They also assume that `beam_in` is already clean and synchronous, so one transition produces one edge. The stimulus drives only legal times. It changes the detector level only at falling clock edges, one level per cycle. The cases include the minute carry, the hour carry, the midnight wrap, and a beam break while the main switch is off.

// File: rtl/alarm_snooze_pkg.sv
package alarm_snooze_pkg;
  localparam int DIGIT_W = 4;
  localparam int TIME_W  = 4 * DIGIT_W;

  typedef struct packed {
    logic [DIGIT_W-1:0] hr_t;
    logic [DIGIT_W-1:0] hr_u;
    logic [DIGIT_W-1:0] mn_t;
    logic [DIGIT_W-1:0] mn_u;
  } bcd_time_t;

  function automatic logic time_legal(input bcd_time_t t, input int hours);
    logic [6:0] h;
    h = 7'(t.hr_t) * 7'd10 + 7'(t.hr_u);
    return (t.mn_u <= 4'd9) && (t.mn_t <= 4'd5) && (t.hr_u <= 4'd9) &&
           (32'(h) < hours);
  endfunction
endpackage

// File: rtl/asc_reset_sync.sv
module asc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/asc_fall_detect.sv
module asc_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic fell
);
  logic prev_q;
  logic prev_d;

  always_comb prev_d = level_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign fell = prev_q & ~level_in;
endmodule

// File: rtl/asc_bcd_advance.sv
module asc_bcd_advance
  import alarm_snooze_pkg::*;
#(
  parameter int ADD_MIN = 2,   // must be below 60
  parameter int HOURS   = 24
) (
  input  bcd_time_t t_in,
  output bcd_time_t t_out
);
  logic [6:0] min_raw, min_fix;
  logic [6:0] hr_raw, hr_inc, hr_fix;
  logic       carry;

  always_comb begin
    min_raw = 7'(t_in.mn_t) * 7'd10 + 7'(t_in.mn_u) + 7'(ADD_MIN);
    carry   = (min_raw >= 7'd60);
    min_fix = carry ? (min_raw - 7'd60) : min_raw;
    hr_raw  = 7'(t_in.hr_t) * 7'd10 + 7'(t_in.hr_u);
    hr_inc  = hr_raw + {6'd0, carry};
    hr_fix  = (hr_inc >= 7'(HOURS)) ? (hr_inc - 7'(HOURS)) : hr_inc;
    t_out.mn_t = 4'(min_fix / 7'd10);
    t_out.mn_u = 4'(min_fix % 7'd10);
    t_out.hr_t = 4'(hr_fix / 7'd10);
    t_out.hr_u = 4'(hr_fix % 7'd10);
  end
endmodule

// File: rtl/asc_target_reg.sv
module asc_target_reg
  import alarm_snooze_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      main_on,
  input  logic      fell,
  input  bcd_time_t rearm_time,
  output logic      snooze_q,
  output bcd_time_t snz_tgt_q
);
  logic      snooze_d;
  bcd_time_t snz_tgt_d;
  logic      load_en;

  always_comb begin
    load_en   = main_on & fell;
    snooze_d  = snooze_q;
    snz_tgt_d = snz_tgt_q;
    if (!main_on) begin
      snooze_d = 1'b0;
    end else if (load_en) begin
      snooze_d  = 1'b1;
      snz_tgt_d = rearm_time;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snooze_q  <= 1'b0;
      snz_tgt_q <= '0;
    end else begin
      snooze_q  <= snooze_d;
      snz_tgt_q <= snz_tgt_d;
    end
  end

  // R6: switch off ends snooze
  assert_off_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !main_on |=> !snooze_q);
  // R3 / R5: beam break with main on loads the re-arm time
  assert_rearm_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (main_on && fell) |=> (snooze_q && snz_tgt_q == $past(rearm_time)));
endmodule

// File: rtl/alarm_snooze_cmp.sv
module alarm_snooze_cmp
  import alarm_snooze_pkg::*;
#(
  parameter int SNOOZE_MIN  = 2,
  parameter int DAY_HOURS   = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              main_on,
  input  logic              beam_in,
  input  logic [TIME_W-1:0] now_time,
  input  logic [TIME_W-1:0] alarm_time,
  output logic              alarm_out
);
  logic      rst_int;
  logic      fell;
  logic      snooze;
  bcd_time_t now_t, rearm_t, snz_tgt, active_tgt;
  logic      match;
  logic      alarm_d, alarm_q;

  assign now_t = bcd_time_t'(now_time);

  asc_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_int));

  asc_fall_detect u_fall (
    .clk(clk), .rst_n(rst_int), .level_in(beam_in), .fell(fell));

  asc_bcd_advance #(.ADD_MIN(SNOOZE_MIN), .HOURS(DAY_HOURS)) u_adv (
    .t_in(now_t), .t_out(rearm_t));

  asc_target_reg u_tgt (
    .clk(clk), .rst_n(rst_int), .main_on(main_on), .fell(fell),
    .rearm_time(rearm_t), .snooze_q(snooze), .snz_tgt_q(snz_tgt));

  always_comb begin
    active_tgt = snooze ? snz_tgt : bcd_time_t'(alarm_time);
    match      = (now_t == active_tgt);
    alarm_d    = main_on & beam_in & match;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) alarm_q <= 1'b0;
    else          alarm_q <= alarm_d;
  end

  assign alarm_out = alarm_q;

  // R1: alarm only with switch on and beam present
  assert_out_gated_R1: assert property (@(posedge clk) disable iff (!rst_int)
    alarm_out |-> ($past(main_on) && $past(beam_in)));
  // R2: outside snooze the programmed time is the target
  assert_plain_match_R2: assert property (@(posedge clk) disable iff (!rst_int)
    (alarm_out && !$past(snooze)) |-> $past(now_time == alarm_time));
  // R4: legal time in gives legal re-arm time out
  assert_rearm_legal_R4: assert property (@(posedge clk) disable iff (!rst_int)
    time_legal(now_t, DAY_HOURS) |-> time_legal(rearm_t, DAY_HOURS));
endmodule

// File: tb/alarm_snooze_cmp_tb.sv
module alarm_snooze_cmp_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        main_on = 1'b0;
  logic        beam_in = 1'b0;
  logic [15:0] now_time = 16'h0000;
  logic [15:0] alarm_time = 16'h0730;
  logic        alarm_out;

  int checks = 0;
  int bad = 0;

  bit    q_exp[$];
  string q_tag[$];

  logic        m_snz = 1'b0;
  logic [15:0] m_tgt = 16'h0000;
  logic        m_prev = 1'b0;

  always #4 clk = ~clk;

  alarm_snooze_cmp u_dut (
    .clk(clk), .rst_n(rst_n), .main_on(main_on), .beam_in(beam_in),
    .now_time(now_time), .alarm_time(alarm_time), .alarm_out(alarm_out));

  function automatic logic [15:0] plus2(input logic [15:0] t);
    int h, m, s;
    h = int'(t[15:12]) * 10 + int'(t[11:8]);
    m = int'(t[7:4]) * 10 + int'(t[3:0]);
    s = (h * 60 + m + 2) % 1440;
    return {4'(s / 600), 4'((s / 60) % 10), 4'((s % 60) / 10), 4'(s % 10)};
  endfunction

  task automatic step(input logic m, input logic b, input logic [15:0] t,
                      input string tag);
    bit e;
    @(negedge clk);
    main_on = m; beam_in = b; now_time = t;
    e = m && b && (t == (m_snz ? m_tgt : alarm_time));
    q_exp.push_back(e);
    q_tag.push_back(tag);
    if (!m) m_snz = 1'b0;
    else if (m_prev && !b) begin m_snz = 1'b1; m_tgt = plus2(t); end
    m_prev = b;
  endtask

  always @(posedge clk) begin
    #2;
    if (q_exp.size() > 0) begin
      bit e;
      string tg;
      e = q_exp.pop_front();
      tg = q_tag.pop_front();
      checks++;
      if (alarm_out !== e) begin
        bad++;
        $display("FAIL %s: alarm_out=%0b expected=%0b", tg, alarm_out, e);
      end
    end
  end

  task automatic break_at(input logic [15:0] t, input string tag);
    step(1'b1, 1'b1, t, tag);
    step(1'b1, 1'b0, t, tag);
  endtask

  initial begin
    #300000000;
    bad++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #20;
    checks++;
    if (alarm_out !== 1'b0) begin
      bad++;
      $display("FAIL R7 reset: alarm_out=%0b expected=0", alarm_out);
    end
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 16'h0730, "R7 idle");
    step(1'b1, 1'b0, 16'h0730, "R7 low after reset no edge");
    step(1'b1, 1'b1, 16'h0730, "R7 R2 match after reset");
    step(1'b0, 1'b1, 16'h0730, "R1 main off");
    step(1'b1, 1'b1, 16'h0729, "R2 before");
    step(1'b1, 1'b1, 16'h0730, "R2 equal");
    step(1'b1, 1'b1, 16'h0731, "R2 after");
    step(1'b1, 1'b0, 16'h0730, "R1 beam low");
    step(1'b1, 1'b1, 16'h0730, "R3 old target gone");
    step(1'b1, 1'b1, 16'h0731, "R3 early");
    step(1'b1, 1'b1, 16'h0732, "R3 snooze hit");
    step(1'b1, 1'b1, 16'h0732, "R9 rise keeps target");
    break_at(16'h0732, "R5 rebreak");
    step(1'b1, 1'b1, 16'h0734, "R5 new target");
    break_at(16'h0759, "R4 minute carry");
    step(1'b1, 1'b1, 16'h0801, "R4 0801");
    break_at(16'h0958, "R4 tens of hours");
    step(1'b1, 1'b1, 16'h1000, "R4 1000");
    break_at(16'h1959, "R4 1959");
    step(1'b1, 1'b1, 16'h2001, "R4 2001");
    break_at(16'h2359, "R4 midnight");
    step(1'b1, 1'b1, 16'h0001, "R4 0001");
    break_at(16'h2358, "R4 2358");
    step(1'b1, 1'b1, 16'h0000, "R4 0000");
    step(1'b1, 1'b1, 16'h0730, "R6 snooze ignores alarm time");
    step(1'b0, 1'b1, 16'h0000, "R6 switch off");
    step(1'b1, 1'b1, 16'h0000, "R6 old snooze target");
    step(1'b1, 1'b1, 16'h0730, "R6 alarm time back");
    step(1'b1, 1'b1, 16'h1200, "R6 prep");
    step(1'b0, 1'b0, 16'h1200, "R6 R8 break with main off");
    step(1'b1, 1'b1, 16'h1202, "R8 no snooze");
    step(1'b1, 1'b1, 16'h0730, "R8 alarm time kept");
    step(1'b1, 1'b1, 16'h0730, "R1 hold");
    step(1'b1, 1'b0, 16'h0730, "R1 break");
    step(1'b0, 1'b0, 16'h0732, "R1 main off at target");
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule